// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It takes two 64-bit operands, a 5-bit condition mask and a width select. It evaluates five relations between the operands: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. The trap request is the OR of the relations that the mask enables.

In narrow (word) mode only the low 32 bits of each operand take part. The signed relations sign-extend those bits and the unsigned relations zero-extend them. In wide (doubleword) mode all 64 bits are compared.

The decision is registered. One clock after a valid strobe, the block presents a trap flag together with a program-exception cause code that the exception logic downstream consumes. Instruction decode and vectoring sit outside this block.

Top module: `trap_cond_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `trap_o` is 0 and `cause_o` is 0.
- R2: Condition bit 4 (value 0x10) enables a trap when operand A is less than operand B, compared as two's-complement numbers.
- R3: Condition bit 3 (value 0x08) enables a trap when A is greater than B, compared as two's-complement numbers.
- R4: Condition bit 2 (value 0x04) enables a trap when A equals B.
- R5: Condition bit 1 (value 0x02) enables a trap when A is less than B as unsigned numbers. Condition bit 0 (value 0x01) enables a trap when A is greater than B as unsigned numbers.
- R6: With `dword_i` = 0 (word mode), only bits 31:0 of each operand are used. Bits 63:32 have no effect. Bit 31 acts as the sign for the signed relations, and the unsigned relations zero-extend.
- R7: With `dword_i` = 1 (doubleword mode), all 64 bits of each operand are compared, so a difference only in bits 63:32 affects the result.
- R8: The trap decision is the OR of all enabled relations. A mask of 0x1F always traps, and a mask of 0x00 never traps.
- R9: `trap_o` reflects the inputs sampled at the previous rising clock edge. It is 0 in any cycle that follows an edge where `valid_i` was 0.
- R10: When `trap_o` is 1, `cause_o` equals the trap cause code TRAP_CAUSE, whose default is 4'h3. When `trap_o` is 0, `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Compare request strobe |
| dword_i | input | 1 | 1 = compare 64 bits, 0 = compare low 32 bits |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| cond_i | input | 5 | Relation enable mask |
| trap_o | output | 1 | Registered trap request |
| cause_o | output | 4 | Registered program-exception cause code |

## Verification
The bench goes after the operands where signed and unsigned order disagree, such as all-ones against one and a word with bit 31 set. A design that swapped or merged the two kinds of compare would trap on the wrong mask bit there.

It also drives operands that differ only in the upper half in both modes. A word-mode design that leaked the upper bits would miss equality. A doubleword design that truncated would falsely match.

Directed cases cover mask 0x00, mask 0x1F and a deasserted strobe, which expose a broken OR reduction or a flag that is not gated by the strobe. A seeded random mix with forced equal operands checks all relations against a bench model, including the cause code staying zero when no trap is raised.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

  // Relation vector; member order matches the condition mask bit order
  // (first member is the most significant bit, mask bit 4).
  typedef struct packed {
    logic lt_s;  // bit 4
    logic gt_s;  // bit 3
    logic eq;    // bit 2
    logic lt_u;  // bit 1
    logic gt_u;  // bit 0
  } rel_t;

  localparam int unsigned REL_N = $bits(rel_t);

endpackage

// File: rtl/trap_opnd_prep.sv
module trap_opnd_prep #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              dword_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] sgn_o,
  output logic [DATA_W-1:0] uns_o
);

  localparam int unsigned EXT_W = DATA_W - WORD_W;

  logic [WORD_W-1:0] low_part;

  assign low_part = opnd_i[WORD_W-1:0];

  always_comb begin
    if (dword_i) begin
      sgn_o = opnd_i;
      uns_o = opnd_i;
    end else begin
      sgn_o = {{EXT_W{low_part[WORD_W-1]}}, low_part};
      uns_o = {{EXT_W{1'b0}}, low_part};
    end
  end

endmodule

// File: rtl/trap_rel_eval.sv
module trap_rel_eval #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]  a_sgn_i,
  input  logic [DATA_W-1:0]  b_sgn_i,
  input  logic [DATA_W-1:0]  a_uns_i,
  input  logic [DATA_W-1:0]  b_uns_i,
  output trap_cmp_pkg::rel_t rel_o
);

  always_comb begin
    rel_o.lt_s = $signed(a_sgn_i) < $signed(b_sgn_i);
    rel_o.gt_s = $signed(a_sgn_i) > $signed(b_sgn_i);
    rel_o.eq   = (a_uns_i == b_uns_i);
    rel_o.lt_u = (a_uns_i < b_uns_i);
    rel_o.gt_u = (a_uns_i > b_uns_i);
  end

endmodule

// File: rtl/trap_mask_or.sv
module trap_mask_or
  import trap_cmp_pkg::*;
(
  input  rel_t             rel_i,
  input  logic [REL_N-1:0] cond_i,
  output logic             hit_o
);

  logic [REL_N-1:0] enabled;

  assign enabled = rel_i & cond_i;
  assign hit_o   = |enabled;

endmodule

// File: rtl/trap_cond_unit.sv
module trap_cond_unit
  import trap_cmp_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned CAUSE_W    = 4,
  parameter logic [CAUSE_W-1:0] TRAP_CAUSE = 4'h3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               dword_i,
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  input  logic [REL_N-1:0]   cond_i,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int unsigned OPND_N = 2;

  logic [OPND_N-1:0][DATA_W-1:0] opnd_in;
  logic [OPND_N-1:0][DATA_W-1:0] opnd_sgn;
  logic [OPND_N-1:0][DATA_W-1:0] opnd_uns;
  rel_t                          rel;
  logic                          hit;
  logic                          trap_d, trap_q;
  logic [CAUSE_W-1:0]            cause_d, cause_q;

  assign opnd_in[0] = opa_i;
  assign opnd_in[1] = opb_i;

  for (genvar gi = 0; gi < OPND_N; gi++) begin : g_prep
    trap_opnd_prep #(
      .DATA_W (DATA_W),
      .WORD_W (WORD_W)
    ) u_prep (
      .dword_i (dword_i),
      .opnd_i  (opnd_in[gi]),
      .sgn_o   (opnd_sgn[gi]),
      .uns_o   (opnd_uns[gi])
    );
  end

  trap_rel_eval #(
    .DATA_W (DATA_W)
  ) u_eval (
    .a_sgn_i (opnd_sgn[0]),
    .b_sgn_i (opnd_sgn[1]),
    .a_uns_i (opnd_uns[0]),
    .b_uns_i (opnd_uns[1]),
    .rel_o   (rel)
  );

  trap_mask_or u_mask (
    .rel_i  (rel),
    .cond_i (cond_i),
    .hit_o  (hit)
  );

  // next-state
  always_comb begin
    trap_d  = valid_i & hit;
    cause_d = trap_d ? TRAP_CAUSE : '0;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  assign trap_o  = trap_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/trap_cond_chk.sv
module trap_cond_chk #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned CAUSE_W    = 4,
  parameter logic [CAUSE_W-1:0] TRAP_CAUSE = 4'h3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               valid_i,
  input logic               dword_i,
  input logic [DATA_W-1:0]  opa_i,
  input logic [DATA_W-1:0]  opb_i,
  input logic [4:0]         cond_i,
  input logic               trap_o,
  input logic [CAUSE_W-1:0] cause_o
);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !trap_o);

  assert_cause_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> cause_o == TRAP_CAUSE);

  assert_cause_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> cause_o == '0);

  assert_full_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 5'h1F) |=> trap_o);

  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 5'h00) |=> !trap_o);

  assert_eq_dword_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && dword_i && cond_i[2] && opa_i == opb_i) |=> trap_o);

  assert_eq_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !dword_i && cond_i[2] &&
     opa_i[WORD_W-1:0] == opb_i[WORD_W-1:0]) |=> trap_o);

endmodule

bind trap_cond_unit trap_cond_chk #(
  .DATA_W     (DATA_W),
  .WORD_W     (WORD_W),
  .CAUSE_W    (CAUSE_W),
  .TRAP_CAUSE (TRAP_CAUSE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid_i (valid_i),
  .dword_i (dword_i),
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .cond_i  (cond_i),
  .trap_o  (trap_o),
  .cause_o (cause_o)
);

// File: tb/trap_cond_unit_tb_top.sv
`timescale 1ns/1ps
module trap_cond_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic        dword_i;
  logic [63:0] opa_i;
  logic [63:0] opb_i;
  logic [4:0]  cond_i;
  logic        trap_o;
  logic [3:0]  cause_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [3:0] CAUSE_EXP = 4'h3;

  always #4 clk = ~clk;

  trap_cond_unit dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .dword_i (dword_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .cond_i  (cond_i),
    .trap_o  (trap_o),
    .cause_o (cause_o)
  );

  function automatic logic model(logic dw, logic [63:0] a, logic [63:0] b,
                                 logic [4:0] m);
    logic signed [63:0] sa, sb;
    logic [63:0] ua, ub;
    if (dw) begin
      sa = a; sb = b; ua = a; ub = b;
    end else begin
      sa = {{32{a[31]}}, a[31:0]};
      sb = {{32{b[31]}}, b[31:0]};
      ua = {32'h0, a[31:0]};
      ub = {32'h0, b[31:0]};
    end
    return (m[4] && (sa < sb)) || (m[3] && (sa > sb)) || (m[2] && (ua == ub)) ||
           (m[1] && (ua < ub)) || (m[0] && (ua > ub));
  endfunction

  task automatic check(string tag, logic exp_t);
    logic [3:0] exp_c;
    exp_c = exp_t ? CAUSE_EXP : 4'h0;
    checks++;
    if (trap_o !== exp_t || cause_o !== exp_c) begin
      errors++;
      $display("FAIL %s: trap=%0b cause=%0h expected trap=%0b cause=%0h",
               tag, trap_o, cause_o, exp_t, exp_c);
    end
  endtask

  // Called at a falling edge; result is checked at the next falling edge.
  task automatic run(string tag, logic v, logic dw, logic [63:0] a,
                     logic [63:0] b, logic [4:0] m);
    valid_i = v; dword_i = dw; opa_i = a; opb_i = b; cond_i = m;
    @(negedge clk);
    check(tag, v && model(dw, a, b, m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; valid_i = 1'b1; dword_i = 1'b1;
    opa_i = 64'h5; opb_i = 64'h5; cond_i = 5'h1F;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    valid_i = 1'b0;
    @(negedge clk);
    check("R1 after release", 1'b0);

    run("R2 signed lt", 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h10);
    run("R5 unsigned lt false", 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h02);
    run("R5 unsigned gt", 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h01);
    run("R3 signed gt", 1, 1, 64'h5, 64'hFFFF_FFFF_FFFF_FFFD, 5'h08);
    run("R3 signed gt false", 1, 1, 64'h5, 64'h9, 5'h08);
    run("R4 equal", 1, 1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04);
    run("R4 not equal", 1, 1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 5'h04);
    run("R6 upper ignored eq", 1, 0, 64'hFFFF_FFFF_0000_0007, 64'h0000_0000_0000_0007, 5'h04);
    run("R6 word sign lt", 1, 0, 64'h0000_0000_8000_0000, 64'h1, 5'h10);
    run("R6 word unsigned gt", 1, 0, 64'h0000_0000_8000_0000, 64'h1, 5'h01);
    run("R6 word upper no gt", 1, 0, 64'h7FFF_0000_0000_0001, 64'h1, 5'h19);
    run("R7 dword upper differ", 1, 1, 64'hFFFF_FFFF_0000_0007, 64'h0000_0000_0000_0007, 5'h04);
    run("R7 dword upper lt_s", 1, 1, 64'h8000_0000_0000_0000, 64'h0, 5'h10);
    run("R8 full mask eq", 1, 1, 64'h42, 64'h42, 5'h1F);
    run("R8 full mask word", 1, 0, 64'hDEAD_BEEF_0000_0001, 64'h3, 5'h1F);
    run("R8 zero mask", 1, 1, 64'h1, 64'h2, 5'h00);
    run("R8 or of relations", 1, 1, 64'h3, 64'h7, 5'h0B);
    run("R9 valid low", 0, 1, 64'h42, 64'h42, 5'h1F);
    run("R9 valid back", 1, 1, 64'h42, 64'h42, 5'h04);
    run("R10 no trap cause", 1, 1, 64'h42, 64'h43, 5'h04);

    for (int i = 0; i < 600; i++) begin
      logic [63:0] a, b;
      logic v, dw;
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      case ($urandom % 4)
        0: b = a;
        1: b = {$urandom, a[31:0]};
        2: b[63] = ~a[63];
        default: ;
      endcase
      v  = ($urandom % 8) != 0;
      dw = $urandom % 2;
      run("R8 random", v, dw, a, b, 5'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule